// File: doc/BRIEF.md
# Memory Access Window Timer

This block decides how long each CPU memory access takes in a 24-bit address space split into fast and slow regions. All timing is counted in cycles of the master clock. The CPU presents a one-cycle request strobe together with the bank byte (address bits 23:16). The block classifies the bank and holds its stall output high until the access is served. It then pulses a done strobe on the last cycle of the window that served the access.

Two cadences run freely from reset, with or without requests. The fast cadence divides time into 5-cycle windows grouped in tens. The last window of each group of ten is taken by DRAM refresh, and a fast-RAM access may not use it. ROM accesses may use any fast window. The slow cadence divides time into 14-cycle windows grouped in sixty-fours, and the last window of each group lasts 16 cycles. This keeps the slow region's video timing in phase with the colour subcarrier. Each access is served by the first suitable window of its class that begins after the request was accepted.

Top module: `bus_window_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it, done_o and stall_o are both 0.
- R2: Banks 0xF0 to 0xFF are ROM. Banks 0xE0 and 0xE1 are slow. Every other bank (including 0x00, 0x01, 0x80 to 0xDF and 0xE2 to 0xEF) is fast RAM.
- R3: Fast windows are 5 cycles long and begin every 5th cycle, counting from the first cycle after reset. A fast access is served by the first eligible fast window that starts after the cycle in which its request was accepted.
- R4: The fast windows are numbered 0 to 9 repeatedly. Window 9 is a refresh window, and a fast-RAM access never starts in it; such an access waits for the next window 0, keeping stall_o high.
- R5: A ROM access may start in any fast window, including a refresh window.
- R6: Slow windows are 14 cycles long and serve banks 0xE0/0xE1, under the same start rule as R3.
- R7: The slow windows are numbered 0 to 63 repeatedly, and window 63 lasts 16 cycles.
- R8: Both cadences advance every cycle whether or not requests arrive, so idle time never shifts window boundaries.
- R9: done_o is high for exactly one cycle, on the last cycle of the serving window. stall_o is high from the cycle after acceptance up to, but not including, that done cycle.
- R10: A request is accepted only when no access is pending. A request strobe while stall_o is high is ignored, and the pending access completes with its original timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | One-cycle access request strobe |
| bank_i | input | 8 | Bank byte of the requested address |
| done_o | output | 1 | Pulses on the last cycle of the serving window |
| stall_o | output | 1 | High while an accepted access waits or is in its window |

## Verification
The bench aims fast-RAM requests at every phase of the ten-window group. This includes requests that land just before and inside window 9. A design that let fast RAM use the refresh window would finish such an access 5 cycles early, while one that also blocked ROM would finish a ROM access late. Back-to-back slow requests run through more than one full group of 64 windows. A design that stretched the wrong window, or restarted the slow count on each access, would move done_o by 2 cycles or more against the free-running model. Strobes issued during a stall with a different bank check that the pending class is not overwritten.

// File: rtl/bwg_pkg.sv
package bwg_pkg;
  typedef enum logic [1:0] {
    CLS_FRAM = 2'd0,
    CLS_ROM  = 2'd1,
    CLS_SLOW = 2'd2
  } acc_cls_e;
endpackage

// File: rtl/bwg_bank_decode.sv
module bwg_bank_decode
  import bwg_pkg::*;
#(
  parameter logic [3:0] ROM_NIBBLE = 4'hF,
  parameter logic [7:0] SLOW_BASE  = 8'hE0
) (
  input  logic [7:0] bank_i,
  output acc_cls_e   cls_o
);
  always_comb begin
    if (bank_i[7:4] == ROM_NIBBLE)              cls_o = CLS_ROM;
    else if (bank_i[7:1] == SLOW_BASE[7:1])     cls_o = CLS_SLOW;
    else                                        cls_o = CLS_FRAM;
  end
endmodule

// File: rtl/bwg_win_cadence.sv
module bwg_win_cadence #(
  parameter int N_WIN    = 10,
  parameter int LEN      = 5,
  parameter int LAST_LEN = 5,
  localparam int MAXL    = (LAST_LEN > LEN) ? LAST_LEN : LEN,
  localparam int PW      = (MAXL > 1) ? $clog2(MAXL) : 1,
  localparam int IW      = (N_WIN > 1) ? $clog2(N_WIN) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [PW-1:0] phase_o,
  output logic [IW-1:0] idx_o,
  output logic          start_o,
  output logic          last_o,
  output logic          final_win_o
);
  localparam logic [PW-1:0] LEN_M1  = PW'(LEN - 1);
  localparam logic [PW-1:0] LAST_M1 = PW'(LAST_LEN - 1);
  localparam logic [IW-1:0] IDX_TOP = IW'(N_WIN - 1);

  logic [PW-1:0] phase_q;
  logic [IW-1:0] idx_q;

  assign final_win_o = (idx_q == IDX_TOP);
  assign start_o     = (phase_q == '0);
  assign last_o      = (phase_q == (final_win_o ? LAST_M1 : LEN_M1));
  assign phase_o     = phase_q;
  assign idx_o       = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      idx_q   <= '0;
    end else if (last_o) begin
      phase_q <= '0;
      idx_q   <= final_win_o ? '0 : idx_q + 1'b1;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/bwg_access_ctrl.sv
module bwg_access_ctrl
  import bwg_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     req_i,
  input  acc_cls_e req_cls_i,
  input  logic     fast_start_i,
  input  logic     fast_last_i,
  input  logic     fast_refresh_i,
  input  logic     slow_start_i,
  input  logic     slow_last_i,
  output acc_cls_e cls_o,
  output logic     done_o,
  output logic     stall_o
);
  logic     pending_q, granted_q;
  acc_cls_e cls_q;
  logic     start, win_last;

  // fast RAM may not open a window during refresh; ROM may
  always_comb begin
    if (cls_q == CLS_SLOW) begin
      start    = slow_start_i;
      win_last = slow_last_i;
    end else begin
      start    = fast_start_i & ((cls_q == CLS_ROM) | ~fast_refresh_i);
      win_last = fast_last_i;
    end
    start = start & pending_q & ~granted_q;
  end

  assign done_o  = pending_q & (granted_q | start) & win_last;
  assign stall_o = pending_q & ~done_o;
  assign cls_o   = cls_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      granted_q <= 1'b0;
      cls_q     <= CLS_FRAM;
    end else if (!pending_q) begin
      if (req_i) begin
        pending_q <= 1'b1;
        granted_q <= 1'b0;
        cls_q     <= req_cls_i;
      end
    end else if (done_o) begin
      pending_q <= 1'b0;
      granted_q <= 1'b0;
    end else if (start) begin
      granted_q <= 1'b1;
    end
  end
endmodule

// File: rtl/bus_window_gen.sv
module bus_window_gen
  import bwg_pkg::*;
#(
  parameter int         FAST_LEN    = 5,
  parameter int         FAST_GROUP  = 10,
  parameter int         SLOW_LEN    = 14,
  parameter int         SLOW_LONG   = 16,
  parameter int         SLOW_GROUP  = 64,
  parameter logic [3:0] ROM_NIBBLE  = 4'hF,
  parameter logic [7:0] SLOW_BASE   = 8'hE0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic [7:0] bank_i,
  output logic       done_o,
  output logic       stall_o
);
  localparam int FPW = $clog2(FAST_LEN);
  localparam int FIW = $clog2(FAST_GROUP);
  localparam int SPW = $clog2((SLOW_LONG > SLOW_LEN) ? SLOW_LONG : SLOW_LEN);
  localparam int SIW = $clog2(SLOW_GROUP);

  acc_cls_e           req_cls, cur_cls;
  logic [FPW-1:0]     f_phase;
  logic [FIW-1:0]     f_idx;
  logic               f_start, f_last, f_refresh;
  logic [SPW-1:0]     s_phase;
  logic [SIW-1:0]     s_idx;
  logic               s_start, s_last, s_long;

  bwg_bank_decode #(.ROM_NIBBLE(ROM_NIBBLE), .SLOW_BASE(SLOW_BASE)) u_dec (
    .bank_i (bank_i),
    .cls_o  (req_cls)
  );

  bwg_win_cadence #(.N_WIN(FAST_GROUP), .LEN(FAST_LEN), .LAST_LEN(FAST_LEN)) u_fast (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .phase_o     (f_phase),
    .idx_o       (f_idx),
    .start_o     (f_start),
    .last_o      (f_last),
    .final_win_o (f_refresh)
  );

  bwg_win_cadence #(.N_WIN(SLOW_GROUP), .LEN(SLOW_LEN), .LAST_LEN(SLOW_LONG)) u_slow (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .phase_o     (s_phase),
    .idx_o       (s_idx),
    .start_o     (s_start),
    .last_o      (s_last),
    .final_win_o (s_long)
  );

  bwg_access_ctrl u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_i          (req_i),
    .req_cls_i      (req_cls),
    .fast_start_i   (f_start),
    .fast_last_i    (f_last),
    .fast_refresh_i (f_refresh),
    .slow_start_i   (s_start),
    .slow_last_i    (s_last),
    .cls_o          (cur_cls),
    .done_o         (done_o),
    .stall_o        (stall_o)
  );
endmodule

// File: rtl/bus_window_gen_chk.sv
module bus_window_gen_chk
  import bwg_pkg::*;
#(
  parameter int SLOW_LEN  = 14,
  parameter int SLOW_LONG = 16,
  parameter int SPW       = 4,
  parameter int SIW       = 6,
  parameter int FPW       = 3,
  parameter int FAST_LEN  = 5
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           req_i,
  input logic           done_o,
  input logic           stall_o,
  input acc_cls_e       cur_cls,
  input logic           f_refresh,
  input logic [FPW-1:0] f_phase,
  input logic           s_last,
  input logic           s_long
);
  logic [7:0] s_len_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     s_len_cnt <= '0;
    else if (s_last) s_len_cnt <= '0;
    else             s_len_cnt <= s_len_cnt + 1'b1;
  end

  a_r9_done_not_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && stall_o));
  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_done_after_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(stall_o));
  a_r10_stall_from_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_o) |-> $past(req_i));
  a_r10_class_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> $stable(cur_cls));
  a_r4_no_refresh_fram: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cur_cls == CLS_FRAM) |-> !f_refresh);
  a_r3_fast_end_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cur_cls != CLS_SLOW) |-> (f_phase == FPW'(FAST_LEN - 1)));
  a_r6_short_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_last && !s_long) |-> (s_len_cnt == 8'(SLOW_LEN - 1)));
  a_r7_long_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_last && s_long) |-> (s_len_cnt == 8'(SLOW_LONG - 1)));
  a_r6_slow_done_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cur_cls == CLS_SLOW) |-> s_last);
endmodule

bind bus_window_gen bus_window_gen_chk #(
  .SLOW_LEN (SLOW_LEN),
  .SLOW_LONG(SLOW_LONG),
  .SPW      (SPW),
  .SIW      (SIW),
  .FPW      (FPW),
  .FAST_LEN (FAST_LEN)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .done_o    (done_o),
  .stall_o   (stall_o),
  .cur_cls   (cur_cls),
  .f_refresh (f_refresh),
  .f_phase   (f_phase),
  .s_last    (s_last),
  .s_long    (s_long)
);

// File: tb/bus_window_gen_test.sv
`timescale 1ns/1ps
module bus_window_gen_test;
  localparam int FL = 5, FG = 10, SL = 14, SX = 16, SG = 64;
  localparam int SUPER = (SG - 1) * SL + SX;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0;
  logic [7:0] bank_i = 8'h00;
  logic       done_o, stall_o;

  int n_chk = 0, n_fail = 0;
  string cur_tag = "R1";

  // model state
  int k = 0;
  int m_pend = 0, m_gnt = 0, m_cls = 0; // 0 fram, 1 rom, 2 slow

  bus_window_gen uut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .bank_i (bank_i),
    .done_o (done_o),
    .stall_o(stall_o)
  );

  always #2.5 clk_i = ~clk_i;

  function automatic int cls_of(input logic [7:0] b);
    if (b >= 8'hF0) return 1;
    if (b == 8'hE0 || b == 8'hE1) return 2;
    return 0;
  endfunction

  // expected outputs for cycle number c: {start, done}
  function automatic void model_eval(input int c, output int st, output int dn);
    int fph, fwin, pos, sph, slast, ph0, lst, ok;
    fph  = c % FL;
    fwin = (c / FL) % FG;
    pos  = c % SUPER;
    if (pos < (SG - 1) * SL) begin
      sph = pos % SL; slast = (sph == SL - 1);
    end else begin
      sph = pos - (SG - 1) * SL; slast = (sph == SX - 1);
    end
    if (m_cls == 2) begin ph0 = (sph == 0); lst = slast; ok = 1; end
    else begin
      ph0 = (fph == 0); lst = (fph == FL - 1);
      ok = (m_cls == 1) || (fwin != FG - 1);
    end
    st = (m_pend && !m_gnt && ph0 && ok) ? 1 : 0;
    dn = (m_pend && (m_gnt || st) && lst) ? 1 : 0;
  endfunction

  always @(posedge clk_i) begin
    if (rst_ni) begin
      int st, dn;
      model_eval(k, st, dn);
      if (!m_pend) begin
        if (req_i) begin m_pend = 1; m_gnt = 0; m_cls = cls_of(bank_i); end
      end else if (dn) begin
        m_pend = 0; m_gnt = 0;
      end else if (st) begin
        m_gnt = 1;
      end
      k = k + 1;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      int st, dn, es;
      model_eval(k, st, dn);
      es = (m_pend && !dn) ? 1 : 0;
      n_chk++;
      if (done_o !== dn[0] || stall_o !== es[0]) begin
        n_fail++;
        $display("FAIL %s cycle %0d: done/stall actual %b/%b expected %0d/%0d",
                 cur_tag, k, done_o, stall_o, dn, es);
      end
    end
  end

  task automatic access(input logic [7:0] b, input int gap, input int poke);
    @(negedge clk_i);
    req_i = 1'b1; bank_i = b;
    @(negedge clk_i);
    req_i = 1'b0;
    if (poke) begin
      // R10: strobe while pending must be ignored
      req_i = 1'b1; bank_i = (b == 8'hE0) ? 8'h10 : 8'hE0;
      @(negedge clk_i);
      req_i = 1'b0;
    end
    while (stall_o) @(negedge clk_i);
    repeat (gap) @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog %s: actual hang expected completion", cur_tag);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    n_chk++;
    if (done_o !== 1'b0 || stall_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 in reset: actual %b/%b expected 0/0", done_o, stall_o);
    end
    rst_ni = 1'b1;
    cur_tag = "R1";
    repeat (4) @(negedge clk_i);

    cur_tag = "R2";
    access(8'h00, 1, 0); access(8'h01, 0, 0); access(8'h80, 2, 0);
    access(8'hDF, 0, 0); access(8'hE2, 3, 0); access(8'hEF, 0, 0);
    access(8'hF0, 1, 0); access(8'hFF, 0, 0); access(8'hE1, 0, 0);

    cur_tag = "R3_R4";
    for (int i = 0; i < 60; i++) access(8'h02 + 8'(i % 5), i % 7, 0);

    cur_tag = "R5";
    for (int i = 0; i < 40; i++) access(8'hF0 | 8'(i % 16), i % 9, 0);

    cur_tag = "R3_R4_R5";
    for (int i = 0; i < 40; i++) access((i % 2) ? 8'hFE : 8'h7F, i % 11, 0);

    cur_tag = "R6_R7";
    for (int i = 0; i < 140; i++) access((i % 2) ? 8'hE1 : 8'hE0, 0, 0);

    cur_tag = "R8";
    repeat (437) @(negedge clk_i);
    for (int i = 0; i < 20; i++) access(8'hE0, 3 + i * 13, 0);

    cur_tag = "R10";
    for (int i = 0; i < 12; i++) access((i % 3 == 0) ? 8'hE0 : ((i % 3 == 1) ? 8'h05 : 8'hF3), i, 1);

    cur_tag = "R9";
    for (int i = 0; i < 30; i++) access(8'(i * 37), i % 4, 0);

    repeat (5) @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule